// File: doc/BRIEF.md
# Two-Road Traffic Lamp Sequencer

This block runs the lamps at a crossing of two roads, east-west and north-south. Each road has its own phase timer: a state register that holds the current lamp phase and a down counter that holds the ticks left in that phase. The phases always follow the same loop, red to yellow to green and back to red. Each phase has its own length, so the single counter of a road works as a counter whose modulus changes at every phase change.

A count-enable tick paces both timers. When the tick is low, nothing moves. On a tick where a road's counter is at zero, that road's timer moves to the next phase and loads that phase's length minus one in the same clock edge. No idle or filler count value appears between two phases. The state and the counter of each road share one clocked process. The lamp outputs are decoded from the registered phase by a separate combinational process.

The phase states are PH_RED, PH_YEL and PH_GRN. There are three transitions, each taken on a tick with the count at zero: RED_TO_YEL, YEL_TO_GRN and GRN_TO_RED. A synchronous reset sends the east-west road to the start of PH_RED and the north-south road to the start of PH_GRN, so the two roads are offset from each other.

Top module: `tl_dual_road`

## Requirements
- R1: While the synchronous reset `rst` is high at a clock edge, the east-west road goes to red with count RED_LEN-1 and the north-south road goes to green with count GRN_LEN-1. Reset takes priority over `tick`.
- R2: Each lamp output is 3 bits wide: bit 0 is red, bit 1 is yellow and bit 2 is green. Exactly one bit of each road's lamp output is set in every cycle after reset.
- R3: Each road's phases follow the order red, yellow, green and then red again, with no other order.
- R4: Within a phase, each tick lowers that road's count by exactly one. The count never skips a value or repeats one.
- R5: On a tick where a road's count is zero, the road enters the next phase and its count becomes that phase's length minus one in the same edge. No other count value appears in between.
- R6: In a cycle where `tick` is low, neither road's lamp nor count changes. This includes a road whose count is zero.
- R7: A phase lasts exactly its length in ticks: RED_LEN, YEL_LEN or GRN_LEN, which default to 9, 3 and 7. With `tick` held high, each phase lasts that many clock cycles.
- R8: The two roads run on independent timers that share the same lengths. The north-south road follows R3 to R7 from its own starting phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable; timers advance only when it is high |
| ew_lamp | output | 3 | East-west lamps, one-hot {green, yellow, red} |
| ew_count | output | CNT_W | East-west ticks left in the current phase |
| ns_lamp | output | 3 | North-south lamps, one-hot {green, yellow, red} |
| ns_count | output | CNT_W | North-south ticks left in the current phase |

## Verification
The hardest case to reach is a cycle with `tick` low while a road's count sits at zero. At that point the phase change is pending, but it must not be taken. Random tick patterns seldom land a low tick exactly at that point. The stimulus therefore steers there on purpose: it keeps the tick high until the bench's own model shows the east-west count at zero, and then drops the tick for several cycles before raising it again. It does this at several phase boundaries in a row, so it covers the boundary into each of the three phases. A reset applied in mid-phase with the tick held high also checks that reset takes priority over counting.

// File: rtl/tl_pkg.sv
package tl_pkg;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_YEL = 2'd1,
        PH_GRN = 2'd2
    } phase_e;

    localparam int LAMP_W   = 3;
    localparam int LAMP_RED = 0;
    localparam int LAMP_YEL = 1;
    localparam int LAMP_GRN = 2;

    function automatic phase_e phase_after(phase_e p);
        phase_e n;
        unique case (p)
            PH_RED:  n = PH_YEL;   // RED_TO_YEL
            PH_YEL:  n = PH_GRN;   // YEL_TO_GRN
            default: n = PH_RED;   // GRN_TO_RED
        endcase
        return n;
    endfunction

endpackage

// File: rtl/tl_phase_timer.sv
module tl_phase_timer
    import tl_pkg::*;
#(
    parameter int     RED_LEN  = 9,
    parameter int     YEL_LEN  = 3,
    parameter int     GRN_LEN  = 7,
    parameter int     CNT_W    = 4,
    parameter phase_e START_PH = PH_RED
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output phase_e           phase,
    output logic [CNT_W-1:0] count
);

    function automatic logic [CNT_W-1:0] last_index(phase_e p);
        logic [CNT_W-1:0] v;
        unique case (p)
            PH_RED:  v = CNT_W'(RED_LEN - 1);
            PH_YEL:  v = CNT_W'(YEL_LEN - 1);
            default: v = CNT_W'(GRN_LEN - 1);
        endcase
        return v;
    endfunction

    // State and counter in one clocked process: the reload happens on the
    // same edge as the phase change, so no filler value ever appears.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= START_PH;
            count <= last_index(START_PH);
        end else if (tick) begin
            if (count == '0) begin
                phase <= phase_after(phase);
                count <= last_index(phase_after(phase));
            end else begin
                count <= count - 1'b1;
            end
        end
    end

endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
    import tl_pkg::*;
(
    input  phase_e            phase,
    output logic [LAMP_W-1:0] lamp
);

    always_comb begin
        lamp = '0;
        unique case (phase)
            PH_RED:  lamp[LAMP_RED] = 1'b1;
            PH_YEL:  lamp[LAMP_YEL] = 1'b1;
            PH_GRN:  lamp[LAMP_GRN] = 1'b1;
            default: lamp[LAMP_RED] = 1'b1;   // unused code fails safe to red
        endcase
    end

endmodule

// File: rtl/tl_dual_road.sv
module tl_dual_road #(
    parameter int RED_LEN = 9,
    parameter int YEL_LEN = 3,
    parameter int GRN_LEN = 7,
    parameter int MAX_LEN = (RED_LEN > YEL_LEN)
                            ? ((RED_LEN > GRN_LEN) ? RED_LEN : GRN_LEN)
                            : ((YEL_LEN > GRN_LEN) ? YEL_LEN : GRN_LEN),
    parameter int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [2:0]       ew_lamp,
    output logic [CNT_W-1:0] ew_count,
    output logic [2:0]       ns_lamp,
    output logic [CNT_W-1:0] ns_count
);
    import tl_pkg::*;

    localparam int NUM_ROADS = 2;
    localparam phase_e ROAD_START [NUM_ROADS] = '{PH_RED, PH_GRN};

    phase_e           road_phase [NUM_ROADS];
    logic [CNT_W-1:0] road_count [NUM_ROADS];
    logic [LAMP_W-1:0] road_lamp [NUM_ROADS];

    for (genvar r = 0; r < NUM_ROADS; r++) begin : g_road
        tl_phase_timer #(
            .RED_LEN  (RED_LEN),
            .YEL_LEN  (YEL_LEN),
            .GRN_LEN  (GRN_LEN),
            .CNT_W    (CNT_W),
            .START_PH (ROAD_START[r])
        ) u_timer (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick),
            .phase (road_phase[r]),
            .count (road_count[r])
        );

        tl_lamp_decode u_dec (
            .phase (road_phase[r]),
            .lamp  (road_lamp[r])
        );
    end

    assign ew_lamp  = road_lamp[0];
    assign ew_count = road_count[0];
    assign ns_lamp  = road_lamp[1];
    assign ns_count = road_count[1];

endmodule

// File: rtl/tl_dual_road_chk.sv
module tl_dual_road_chk #(
    parameter int RED_LEN = 9,
    parameter int YEL_LEN = 3,
    parameter int GRN_LEN = 7,
    parameter int CNT_W   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [2:0]       ew_lamp,
    input logic [CNT_W-1:0] ew_count,
    input logic [2:0]       ns_lamp,
    input logic [CNT_W-1:0] ns_count
);
    localparam logic [2:0] L_RED = 3'b001;
    localparam logic [2:0] L_YEL = 3'b010;
    localparam logic [2:0] L_GRN = 3'b100;

    initial begin
        a_len_legal_r7: assert (RED_LEN >= 1 && YEL_LEN >= 1 && GRN_LEN >= 1)
            else $error("phase lengths must be at least 1");
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (ew_lamp == L_RED && ew_count == CNT_W'(RED_LEN - 1) &&
                 ns_lamp == L_GRN && ns_count == CNT_W'(GRN_LEN - 1)));

    p_one_lamp_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(ew_lamp) == 1 && $countones(ns_lamp) == 1);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(ew_lamp) && $stable(ew_count) &&
                   $stable(ns_lamp) && $stable(ns_count)));

    p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && ew_count != '0) |=>
            (ew_count == $past(ew_count) - 1'b1 && $stable(ew_lamp)));

    p_ns_count_down_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && ns_count != '0) |=>
            (ns_count == $past(ns_count) - 1'b1 && $stable(ns_lamp)));

    p_red_to_yel_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && ew_count == '0 && ew_lamp == L_RED) |=>
            (ew_lamp == L_YEL && ew_count == CNT_W'(YEL_LEN - 1)));

    p_yel_to_grn_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && ew_count == '0 && ew_lamp == L_YEL) |=>
            (ew_lamp == L_GRN && ew_count == CNT_W'(GRN_LEN - 1)));

    p_grn_to_red_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && ew_count == '0 && ew_lamp == L_GRN) |=>
            (ew_lamp == L_RED && ew_count == CNT_W'(RED_LEN - 1)));

    p_ns_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && ns_count == '0 && ns_lamp == L_GRN) |=>
            (ns_lamp == L_RED && ns_count == CNT_W'(RED_LEN - 1)));

endmodule

bind tl_dual_road tl_dual_road_chk #(
    .RED_LEN (RED_LEN),
    .YEL_LEN (YEL_LEN),
    .GRN_LEN (GRN_LEN),
    .CNT_W   (CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .ew_lamp  (ew_lamp),
    .ew_count (ew_count),
    .ns_lamp  (ns_lamp),
    .ns_count (ns_count)
);

// File: tb/sim_tl_dual_road.sv
module sim_tl_dual_road;
    localparam int CLK_P  = 10;
    localparam int D_RED  = 9;
    localparam int D_YEL  = 3;
    localparam int D_GRN  = 7;
    localparam int CW     = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic [2:0]    ew_lamp, ns_lamp;
    logic [CW-1:0] ew_count, ns_count;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    typedef struct {
        int    ewl, ewc, nsl, nsc;
        bit    ticked;
        bit    was_rst;
        string tag_ew;
        string tag_ns;
    } exp_t;

    exp_t exp_q[$];

    // Bench model: phase 0 red, 1 yellow, 2 green; lamp = 1 << phase
    int m_ew_ph, m_ew_cnt, m_ns_ph, m_ns_cnt;

    tl_dual_road u0 (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .ew_lamp  (ew_lamp),
        .ew_count (ew_count),
        .ns_lamp  (ns_lamp),
        .ns_count (ns_count)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int dur(int ph);
        return (ph == 0) ? D_RED : (ph == 1) ? D_YEL : D_GRN;
    endfunction

    function automatic int dur_of_lamp(int l);
        return (l == 1) ? D_RED : (l == 2) ? D_YEL : D_GRN;
    endfunction

    task automatic model_step(inout int ph, inout int cnt, input bit t,
                              output string tag);
        if (!t) begin
            tag = "R6";
        end else if (cnt == 0) begin
            ph  = (ph + 1) % 3;
            cnt = dur(ph) - 1;
            tag = "R3 R5";
        end else begin
            cnt = cnt - 1;
            tag = "R4";
        end
    endtask

    task automatic drive(bit r, bit t);
        exp_t e;
        @(negedge clk);
        rst  = r;
        tick = t;
        if (r) begin
            m_ew_ph = 0; m_ew_cnt = D_RED - 1;
            m_ns_ph = 2; m_ns_cnt = D_GRN - 1;
            e.tag_ew = "R1";
            e.tag_ns = "R1 R8";
        end else begin
            model_step(m_ew_ph, m_ew_cnt, t, e.tag_ew);
            model_step(m_ns_ph, m_ns_cnt, t, e.tag_ns);
            e.tag_ns = {e.tag_ns, " R8"};
        end
        e.ewl = 1 << m_ew_ph; e.ewc = m_ew_cnt;
        e.nsl = 1 << m_ns_ph; e.nsc = m_ns_cnt;
        e.ticked  = t && !r;
        e.was_rst = r;
        exp_q.push_back(e);
    endtask

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Monitor: pops one expected item per clock, samples after the edge
    int ew_run, ns_run, ew_prev, ns_prev;
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(ew_lamp) == e.ewl, e.tag_ew, "ew_lamp", ew_lamp, e.ewl);
                check(int'(ew_count) == e.ewc, e.tag_ew, "ew_count", ew_count, e.ewc);
                check(int'(ns_lamp) == e.nsl, e.tag_ns, "ns_lamp", ns_lamp, e.nsl);
                check(int'(ns_count) == e.nsc, e.tag_ns, "ns_count", ns_count, e.nsc);
                // R2: exactly one lamp per road
                check($countones(ew_lamp) == 1, "R2", "ew lamps lit", $countones(ew_lamp), 1);
                check($countones(ns_lamp) == 1, "R2", "ns lamps lit", $countones(ns_lamp), 1);
                // R7: ticks spent in each finished phase
                if (e.was_rst) begin
                    ew_run = 0; ns_run = 0;
                    ew_prev = int'(ew_lamp); ns_prev = int'(ns_lamp);
                end else if (e.ticked) begin
                    if (int'(ew_lamp) != ew_prev) begin
                        check(ew_run + 1 == dur_of_lamp(ew_prev), "R7", "ew phase ticks",
                              ew_run + 1, dur_of_lamp(ew_prev));
                        ew_run = 0; ew_prev = int'(ew_lamp);
                    end else ew_run++;
                    if (int'(ns_lamp) != ns_prev) begin
                        check(ns_run + 1 == dur_of_lamp(ns_prev), "R7 R8", "ns phase ticks",
                              ns_run + 1, dur_of_lamp(ns_prev));
                        ns_run = 0; ns_prev = int'(ns_lamp);
                    end else ns_run++;
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        drive(1, 0);
        drive(1, 0);
        for (int i = 0; i < 6; i++) drive(0, 0);           // R6 hold at start
        for (int i = 0; i < 80; i++) drive(0, 1);          // R3 R4 R7, > 3 loops
        for (int i = 0; i < 120; i++) drive(0, (i % 3) != 0);
        for (int i = 0; i < 5; i++) drive(0, 1);
        drive(1, 1);                                       // R1 reset beats tick
        for (int k = 0; k < 4; k++) begin                  // R6 hold at count zero
            while (m_ew_cnt != 0) drive(0, 1);
            for (int j = 0; j < 3; j++) drive(0, 0);
            drive(0, 1);
        end
        for (int i = 0; i < 70; i++) drive(0, 1);
        drive(0, 0);
        while (exp_q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule